// File: doc/BRIEF.md
# Banked Palette RAM with RGB Decode

This block holds a colour palette as byte-wide RAM that a CPU reaches through a 512-byte window. The palette store itself is twice the window size: 1 KiB, organised as 512 two-byte colour entries. A single bank-select input picks which half of the store the window reaches. Only one bit of the system's bank register drives this input. The other bits of that register are handled elsewhere.

Each entry is stored little-endian. The even byte address holds the low byte of the entry and the odd address holds the high byte. Every CPU byte write rebuilds the full 16-bit entry from the new byte and its stored partner byte, then splits it into three 4-bit colour components. Each component is widened to 8 bits. The result goes out on a colour-update port together with the entry index, so a downstream colour lookup table can be kept in step with the store.

CPU reads return the raw stored byte. The colour-update port is a plain one-cycle strobe and has no ready input. It cannot apply back-pressure, so a consumer must accept one update per cycle. The CPU side can issue a write every cycle, and each write produces exactly one update.

Top module: `pal_bank_ram`

## Requirements
- R1: During and just after reset, `col_valid`, `bus_rvalid` and `bus_rdata` are all zero.
- R2: The store byte address is `{win_sel, bus_addr}`. With `win_sel`=0 the window reaches bytes 0..511, and with `win_sel`=1 it reaches bytes 512..1023. The same window offset in the two banks names independent bytes.
- R3: `col_index` of an update equals the store byte address shifted right by one, which is `{win_sel, bus_addr[8:1]}`.
- R4: An entry is little-endian. A write to an even offset replaces the low byte and a write to an odd offset replaces the high byte. The update combines the new byte with the partner byte already stored at the other address of the same entry.
- R5: Each cycle with `bus_wr`=1 produces `col_valid`=1 in exactly the next cycle. A cycle without a write produces `col_valid`=0 in the next cycle.
- R6: Red comes from entry bits 3:0, green from bits 7:4 and blue from bits 11:8. Entry bits 15:12 have no effect on the colour outputs.
- R7: Each 4-bit component is widened by repeating the nibble in both halves, so 0xF gives 0xFF and 0x5 gives 0x55.
- R8: A read strobe returns the stored byte on `bus_rdata` one clock later, with `bus_rvalid`=1 for that one cycle. `bus_rdata` holds its value while no read is issued.
- R9: When a read and a write hit the same byte in one cycle, the read returns the byte as it was before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_sel | input | 1 | Bank select: 1 maps the window onto the upper half of the store |
| bus_addr | input | 9 | Byte offset within the CPU window |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| col_valid | output | 1 | Colour update strobe |
| col_index | output | 9 | Entry index of the update |
| col_red | output | 8 | Widened red component |
| col_green | output | 8 | Widened green component |
| col_blue | output | 8 | Widened blue component |

## Verification
The bench builds the block with its default parameters: 512 entries and a 9-bit window offset. At this size the whole store can be cleared by writing every byte in both banks. After that clear, every partner byte has a known value. The bench then reaches the extreme offsets 0 and 0x1FF in both banks, including index 511, which can only be reached through the upper bank. It also writes high-byte values with bits 15:12 set and exercises a read and a write to the same byte in one cycle.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int COMP_W = 4;            // stored width of one colour component
  localparam int CH_W   = 8;            // widened width of one colour component
  localparam int NCH    = 3;            // red, green, blue
  localparam int KEEP_W = NCH * COMP_W; // entry bits that carry colour

  typedef struct packed {
    logic [CH_W-1:0] red;
    logic [CH_W-1:0] green;
    logic [CH_W-1:0] blue;
  } rgb_t;

  // Repeat a component's bits from the MSB down until CH_W bits are filled.
  function automatic logic [CH_W-1:0] widen(input logic [COMP_W-1:0] c);
    logic [CH_W-1:0] o;
    for (int i = 0; i < CH_W; i++) begin
      o[i] = c[COMP_W-1 - ((CH_W-1-i) % COMP_W)];
    end
    return o;
  endfunction

endpackage

// File: rtl/pal_addr_map.sv
module pal_addr_map #(
  parameter int IDX_W = 9
) (
  input  logic             win_sel,
  input  logic [IDX_W-1:0] off,
  output logic [IDX_W-1:0] idx,
  output logic             odd
);

  localparam int BA_W = IDX_W + 1;

  logic [BA_W-1:0] byte_addr;

  always_comb begin
    byte_addr = {win_sel, off};
    idx       = byte_addr[BA_W-1:1];
    odd       = byte_addr[0];
  end

endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             odd,
  input  logic [7:0]       wdata,
  output logic [7:0]       partner,
  output logic [7:0]       rdata,
  output logic             rvalid
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [7:0] lo_mem [ENTRIES];
  logic [7:0] hi_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (odd) hi_mem[idx] <= wdata;
      else     lo_mem[idx] <= wdata;
    end
  end

  // Partner lane of the same entry, read before this cycle's write lands.
  always_comb partner = odd ? lo_mem[idx] : hi_mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= odd ? hi_mem[idx] : lo_mem[idx];
    end
  end

  // R8: a read strobe gives a valid strobe next cycle, and nothing else does
  a_r8_rvalid_follows_rd: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  a_r8_rvalid_only_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  // R8: read data holds while no read is issued
  a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/pal_rgb_decode.sv
module pal_rgb_decode
  import pal_pkg::*;
(
  input  logic [KEEP_W-1:0] entry,
  output rgb_t              rgb
);

  logic [CH_W-1:0] ch [NCH];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_comb ch[k] = widen(entry[k*COMP_W +: COMP_W]);
  end

  always_comb begin
    rgb.red   = ch[0];
    rgb.green = ch[1];
    rgb.blue  = ch[2];
  end

endmodule

// File: rtl/pal_bank_ram.sv
module pal_bank_ram
  import pal_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_sel,
  input  logic [IDX_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             bus_rvalid,
  output logic             col_valid,
  output logic [IDX_W-1:0] col_index,
  output logic [CH_W-1:0]  col_red,
  output logic [CH_W-1:0]  col_green,
  output logic [CH_W-1:0]  col_blue
);

  localparam int HI_KEEP = KEEP_W - 8;  // colour bits taken from the high byte

  logic [IDX_W-1:0]  idx;
  logic              odd;
  logic [7:0]        partner;
  logic [KEEP_W-1:0] entry_d, entry_q;
  rgb_t              rgb;

  pal_addr_map #(.IDX_W(IDX_W)) u_map (
    .win_sel (win_sel),
    .off     (bus_addr),
    .idx     (idx),
    .odd     (odd)
  );

  pal_store #(.IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .rd_en   (bus_rd),
    .idx     (idx),
    .odd     (odd),
    .wdata   (bus_wdata),
    .partner (partner),
    .rdata   (bus_rdata),
    .rvalid  (bus_rvalid)
  );

  // Merge the new byte with its stored partner; high nibble of entry dropped.
  always_comb begin
    if (odd) entry_d = {bus_wdata[HI_KEEP-1:0], partner};
    else     entry_d = {partner[HI_KEEP-1:0], bus_wdata};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_valid <= 1'b0;
      col_index <= '0;
      entry_q   <= '0;
    end else begin
      col_valid <= bus_wr;
      if (bus_wr) begin
        col_index <= idx;
        entry_q   <= entry_d;
      end
    end
  end

  pal_rgb_decode u_dec (
    .entry (entry_q),
    .rgb   (rgb)
  );

  always_comb begin
    col_red   = rgb.red;
    col_green = rgb.green;
    col_blue  = rgb.blue;
  end

  // R5: one update in the cycle after every write, none otherwise
  a_r5_update_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> col_valid);
  a_r5_no_spurious_update: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> !col_valid);
  // R3: index is the banked byte address halved
  a_r3_index_from_port: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> col_index == $past({win_sel, bus_addr[IDX_W-1:1]}));
  // R7: widened channels carry the nibble in both halves
  a_r7_red_halves: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> col_red[7:4] == col_red[3:0]);
  a_r7_blue_halves: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> col_blue[7:4] == col_blue[3:0]);

endmodule

// File: tb/pal_bank_ram_tb.sv
`timescale 1ns/1ps
module pal_bank_ram_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       win_sel;
  logic [8:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic       col_valid;
  logic [8:0] col_index;
  logic [7:0] col_red, col_green, col_blue;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pal_bank_ram u_dut (
    .clk(clk), .rst_n(rst_n), .win_sel(win_sel), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .col_valid(col_valid),
    .col_index(col_index), .col_red(col_red), .col_green(col_green),
    .col_blue(col_blue)
  );

  typedef struct packed {
    logic       bank;
    logic [8:0] off;
    logic [7:0] data;
    logic [8:0] idx;
    logic [7:0] r, g, b;
  } vec_t;

  // Applied after the whole store is cleared to zero.
  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 9'h000, 8'h21, 9'd0,   8'h11, 8'h22, 8'h00},
    '{1'b0, 9'h001, 8'h03, 9'd0,   8'h11, 8'h22, 8'h33},
    '{1'b0, 9'h001, 8'hF3, 9'd0,   8'h11, 8'h22, 8'h33},
    '{1'b1, 9'h000, 8'hAF, 9'd256, 8'hFF, 8'hAA, 8'h00},
    '{1'b1, 9'h001, 8'h0C, 9'd256, 8'hFF, 8'hAA, 8'hCC},
    '{1'b0, 9'h1FF, 8'h05, 9'd255, 8'h00, 8'h00, 8'h55},
    '{1'b1, 9'h1FF, 8'h0E, 9'd511, 8'h00, 8'h00, 8'hEE},
    '{1'b1, 9'h1FE, 8'h7B, 9'd511, 8'hBB, 8'h77, 8'hEE},
    '{1'b0, 9'h000, 8'h9D, 9'd0,   8'hDD, 8'h99, 8'h33},
    '{1'b0, 9'h0A5, 8'h46, 9'd82,  8'h00, 8'h00, 8'h66}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  // Drive one write at a falling edge; return at the next falling edge.
  task automatic wr_byte(input logic bank, input logic [8:0] off, input logic [7:0] d);
    @(negedge clk);
    win_sel = bank; bus_addr = off; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_byte(input logic bank, input logic [8:0] off, input logic [7:0] exp, input string req);
    @(negedge clk);
    win_sel = bank; bus_addr = off; bus_rd = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    idle();
    chk({req, " rvalid"}, bus_rvalid, 1);
    chk({req, " rdata"}, bus_rdata, exp);
  endtask

  initial begin
    rst_n = 1'b0; win_sel = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle();
    repeat (3) @(negedge clk);
    chk("R1 col_valid", col_valid, 0);
    chk("R1 rvalid", bus_rvalid, 0);
    chk("R1 rdata", bus_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 col_valid after release", col_valid, 0);

    // Clear both banks so every partner byte is known.
    for (int bk = 0; bk < 2; bk++) begin
      for (int a = 0; a < 512; a++) begin
        @(negedge clk);
        win_sel = bk[0]; bus_addr = a[8:0]; bus_wdata = 8'h00; bus_wr = 1'b1;
      end
    end
    @(negedge clk);
    idle();
    chk("R5 update after last clear write", col_valid, 1);
    @(negedge clk);
    chk("R5 no update when idle", col_valid, 0);

    // Vector table: R2 R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr_byte(TBL[i].bank, TBL[i].off, TBL[i].data);
      chk($sformatf("R5 vec%0d valid", i), col_valid, 1);
      chk($sformatf("R3 vec%0d index", i), col_index, TBL[i].idx);
      chk($sformatf("R4/R6/R7 vec%0d red", i), col_red, TBL[i].r);
      chk($sformatf("R4/R6/R7 vec%0d green", i), col_green, TBL[i].g);
      chk($sformatf("R4/R6/R7 vec%0d blue", i), col_blue, TBL[i].b);
      @(negedge clk);
      chk($sformatf("R5 vec%0d pulse is one cycle", i), col_valid, 0);
    end

    // Read-back: bank independence and raw bytes (R2, R8)
    rd_byte(1'b0, 9'h000, 8'h9D, "R2 bank0 off0");
    rd_byte(1'b1, 9'h000, 8'hAF, "R2 bank1 off0");
    rd_byte(1'b0, 9'h001, 8'hF3, "R8 raw high byte");
    rd_byte(1'b1, 9'h1FE, 8'h7B, "R2 bank1 top entry");
    @(negedge clk);
    chk("R8 rvalid drops", bus_rvalid, 0);
    chk("R8 rdata holds", bus_rdata, 8'h7B);

    // Simultaneous read and write to the same byte (R9)
    @(negedge clk);
    win_sel = 1'b0; bus_addr = 9'h0A5; bus_wdata = 8'h11; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    idle();
    chk("R9 old byte returned", bus_rdata, 8'h46);
    chk("R9 update still issued", col_valid, 1);
    chk("R6 blue from new high byte", col_blue, 8'h11);
    rd_byte(1'b0, 9'h0A5, 8'h11, "R9 new byte stored");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule